// File: doc/BRIEF.md
# Timer Event Flag Register

This block keeps the pending-event status of an eight-channel capture/compare timer. The timer core sends a one-cycle pulse whenever a channel captures or compares, and another whenever the free-running counter wraps. Each pulse latches a sticky flag. Software sees the flags through a byte-wide register bus and acknowledges them by writing ones. A combined interrupt request is raised whenever an enabled flag is pending.

Explicit acknowledges count only while the timer or the pulse accumulator is running. An optional fast-acknowledge mode lets driver code skip the explicit write. In that mode the flag is cleared as a side effect of the access that services the event:

- reading a capture channel's data clears that channel's flag;
- writing a compare channel's data clears that channel's flag;
- touching the counter clears the wrap flag.

Each channel's capture or compare role comes from a per-channel mode input.

Top module: `tflag_status`

## Requirements
- R1: While `rst` is high at a clock edge, every channel flag and the wrap flag are 0 after that edge, and `irq` is 0.
- R2: A high `chan_evt[i]` at a clock edge makes `chan_flag[i]` 1 after that edge, and a high `ovf_evt` makes `ovf_flag` 1. A flag never rises without its event.
- R3: A bus write (`bus_sel`=1, `bus_wr`=1) to address 0x0E clears each channel flag whose data bit is 1, with bit i belonging to channel i. Channel flags whose data bit is 0 keep their value.
- R4: A bus write to address 0x0F with data bit 7 set clears the wrap flag. Bit 7 clear leaves the wrap flag unchanged.
- R5: The write-one clears of R3 and R4 take effect only while `tmr_en` or `acc_en` is 1. When both are 0 the write changes no flag.
- R6: If a flag's event and a clear of that flag arrive in the same cycle, the flag is 1 afterwards.
- R7: When `bus_sel`=1 and `bus_wr`=0, `bus_rdata` shows the following in the same cycle:
  - address 0x0E: the channel flags, with bit i for channel i;
  - address 0x0F: the wrap flag in bit 7 and zeros in bits 6..0;
  - any other address: 0.

  When `bus_sel`=0, `bus_rdata` is 0.
- R8: With `fast_clr`=1, a bus read of either byte of channel i's data register clears `chan_flag[i]` when `oc_mode[i]`=0 (capture). The bytes are at address 0x10+2i for the high byte and 0x11+2i for the low byte. This clear does not depend on `tmr_en` or `acc_en`.
- R9: With `fast_clr`=1, a bus write to either byte of channel i's data register clears `chan_flag[i]` when `oc_mode[i]`=1 (compare).
- R10: A read of a compare channel's data, a write to a capture channel's data, or any channel-data access while `fast_clr`=0 leaves the channel flags unchanged.
- R11: With `fast_clr`=1, a read or a write of counter address 0x04 (high byte) or 0x05 (low byte) clears `ovf_flag`.
- R12: `irq` is 1 exactly when some `chan_flag[i]` and `chan_ie[i]` are both 1, or when `ovf_flag` and `ovf_ie` are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| tmr_en | input | 1 | Timer running |
| acc_en | input | 1 | Pulse accumulator running |
| fast_clr | input | 1 | Fast-acknowledge mode |
| oc_mode | input | 8 | Per channel: 1 = compare, 0 = capture |
| chan_evt | input | 8 | Per-channel event pulses |
| ovf_evt | input | 1 | Counter wrap pulse |
| chan_ie | input | 8 | Per-channel interrupt enables |
| ovf_ie | input | 1 | Wrap interrupt enable |
| chan_flag | output | 8 | Channel flags |
| ovf_flag | output | 1 | Wrap flag |
| irq | output | 1 | Combined interrupt request |

## Verification
Every flag is a register that drives a port directly. A wrong set or clear decision therefore shows on `chan_flag` or `ovf_flag` at the first sample after the offending edge, and on `irq` in that same sample whenever the flag is enabled. Errors in the read path show in the same cycle on `bus_rdata`.

Access-side-effect errors need a specific combination to appear: the right mode bit, the right access direction and the right byte of the pair. The bench therefore aims directed accesses at both bytes of a channel, in both directions, and then adds random traffic compared every cycle against a bench model.

// File: rtl/tflag_pkg.sv
package tflag_pkg;
    localparam int NCH      = 8;
    localparam int AW       = 5;
    localparam int DW       = 8;
    localparam int IDX_W    = $clog2(NCH);
    localparam int IDX_LSB  = 1;               // two bytes per channel
    localparam int OVF_BIT  = DW - 1;

    localparam logic [AW-1:0] A_CHFLG   = 5'h0E;
    localparam logic [AW-1:0] A_OVFLG   = 5'h0F;
    localparam logic [AW-1:0] A_CNT     = 5'h04;
    localparam logic [AW-1:0] A_CHBASE  = 5'h10;
    localparam logic [AW-1:0] CH_MASK   = ~(AW'((NCH * 2) - 1));

    typedef struct packed {
        logic           ovf;
        logic [NCH-1:0] ch;
    } flagvec_t;

    localparam int FW = $bits(flagvec_t);

    function automatic logic [IDX_W-1:0] chan_of(input logic [AW-1:0] a);
        return a[IDX_LSB +: IDX_W];
    endfunction

    function automatic logic is_chan(input logic [AW-1:0] a);
        return (a & CH_MASK) == A_CHBASE;
    endfunction

    function automatic logic is_cnt(input logic [AW-1:0] a);
        return a[AW-1:1] == A_CNT[AW-1:1];
    endfunction
endpackage

// File: rtl/tflag_decode.sv
module tflag_decode
    import tflag_pkg::*;
(
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          tmr_en,
    input  logic          acc_en,
    input  logic          fast_clr,
    input  logic [NCH-1:0] oc_mode,
    output flagvec_t      clr
);
    logic             wr_ok;
    logic [IDX_W-1:0] idx;

    always_comb begin
        clr   = '0;
        wr_ok = bus_sel && bus_wr && (tmr_en || acc_en);
        idx   = chan_of(bus_addr);
        // explicit write-one acknowledge
        if (wr_ok && bus_addr == A_CHFLG) clr.ch  = bus_wdata[NCH-1:0];
        if (wr_ok && bus_addr == A_OVFLG) clr.ovf = bus_wdata[OVF_BIT];
        // access side effects
        if (bus_sel && fast_clr) begin
            if (is_chan(bus_addr) && (bus_wr == oc_mode[idx])) clr.ch[idx] = 1'b1;
            if (is_cnt(bus_addr)) clr.ovf = 1'b1;
        end
    end
endmodule

// File: rtl/tflag_bank.sv
module tflag_bank #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)         q[i] <= 1'b0;
            else if (set[i]) q[i] <= 1'b1;   // set has priority
            else if (clr[i]) q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/tflag_irq.sv
module tflag_irq
    import tflag_pkg::*;
(
    input  flagvec_t       flags,
    input  logic [NCH-1:0] chan_ie,
    input  logic           ovf_ie,
    output logic           irq
);
    always_comb irq = (|(flags.ch & chan_ie)) || (flags.ovf && ovf_ie);
endmodule

// File: rtl/tflag_status.sv
module tflag_status
    import tflag_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_sel,
    input  logic           bus_wr,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    input  logic           tmr_en,
    input  logic           acc_en,
    input  logic           fast_clr,
    input  logic [NCH-1:0] oc_mode,
    input  logic [NCH-1:0] chan_evt,
    input  logic           ovf_evt,
    input  logic [NCH-1:0] chan_ie,
    input  logic           ovf_ie,
    output logic [NCH-1:0] chan_flag,
    output logic           ovf_flag,
    output logic           irq
);
    flagvec_t clr, setv, flags;

    assign setv.ch  = chan_evt;
    assign setv.ovf = ovf_evt;

    tflag_decode u_dec (
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .tmr_en(tmr_en), .acc_en(acc_en),
        .fast_clr(fast_clr), .oc_mode(oc_mode), .clr(clr)
    );

    tflag_bank #(.W(FW)) u_bank (
        .clk(clk), .rst(rst), .set(setv), .clr(clr), .q(flags)
    );

    tflag_irq u_irq (
        .flags(flags), .chan_ie(chan_ie), .ovf_ie(ovf_ie), .irq(irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            if (bus_addr == A_CHFLG) bus_rdata[NCH-1:0] = flags.ch;
            if (bus_addr == A_OVFLG) bus_rdata[OVF_BIT] = flags.ovf;
        end
    end

    assign chan_flag = flags.ch;
    assign ovf_flag  = flags.ovf;
endmodule

// File: rtl/tflag_chk.sv
module tflag_chk
    import tflag_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           bus_sel,
    input logic [AW-1:0]  bus_addr,
    input logic [DW-1:0]  bus_rdata,
    input logic           tmr_en,
    input logic           acc_en,
    input logic           fast_clr,
    input logic [NCH-1:0] chan_evt,
    input logic           ovf_evt,
    input logic [NCH-1:0] chan_flag,
    input logic           ovf_flag
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (chan_flag == '0 && !ovf_flag));

    p_event_sets_r2: assert property (@(posedge clk) disable iff (rst)
        (chan_evt != '0) |=> ((chan_flag & $past(chan_evt)) == $past(chan_evt)));

    p_wrap_sets_r6: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |=> ovf_flag);

    p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((chan_flag & ~$past(chan_flag) & ~$past(chan_evt)) == '0));

    p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!tmr_en && !acc_en && !fast_clr) |=>
        (((chan_flag & $past(chan_flag)) == $past(chan_flag)) && (ovf_flag || !$past(ovf_flag))));

    p_wrap_pad_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_addr == A_OVFLG) |-> (bus_rdata[OVF_BIT-1:0] == '0));
endmodule

bind tflag_status tflag_chk u_chk (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_addr(bus_addr),
    .bus_rdata(bus_rdata), .tmr_en(tmr_en), .acc_en(acc_en),
    .fast_clr(fast_clr), .chan_evt(chan_evt), .ovf_evt(ovf_evt),
    .chan_flag(chan_flag), .ovf_flag(ovf_flag)
);

// File: tb/sim_tflag_status.sv
module sim_tflag_status;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 0, bus_wr = 0;
    logic [4:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0, bus_rdata;
    logic       tmr_en = 0, acc_en = 0, fast_clr = 0;
    logic [7:0] oc_mode = 8'hF0, chan_evt = 0, chan_ie = 0;
    logic       ovf_evt = 0, ovf_ie = 0;
    logic [7:0] chan_flag;
    logic       ovf_flag, irq;

    int checks = 0, fails = 0;
    logic [7:0] m_ch = 0;
    logic       m_ovf = 0;

    always #2.5 clk = ~clk;

    tflag_status u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tmr_en(tmr_en), .acc_en(acc_en), .fast_clr(fast_clr),
        .oc_mode(oc_mode), .chan_evt(chan_evt), .ovf_evt(ovf_evt),
        .chan_ie(chan_ie), .ovf_ie(ovf_ie), .chan_flag(chan_flag),
        .ovf_flag(ovf_flag), .irq(irq)
    );

    // clear mask from R3, R4, R5, R8, R9, R10, R11; bit 8 = wrap flag
    function automatic logic [8:0] exp_clr();
        logic [8:0] c = '0;
        if (bus_sel && bus_wr && (tmr_en || acc_en)) begin
            if (bus_addr == 5'h0E) c[7:0] = bus_wdata;
            if (bus_addr == 5'h0F) c[8]   = bus_wdata[7];
        end
        if (bus_sel && fast_clr) begin
            if (bus_addr >= 5'h10 && (bus_wr == oc_mode[bus_addr[3:1]]))
                c[bus_addr[3:1]] = 1'b1;
            if (bus_addr == 5'h04 || bus_addr == 5'h05) c[8] = 1'b1;
        end
        return c;
    endfunction

    function automatic logic [7:0] exp_rd();
        if (!bus_sel || bus_wr) return 8'h00;
        if (bus_addr == 5'h0E) return m_ch;
        if (bus_addr == 5'h0F) return {m_ovf, 7'b0};
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        logic [8:0] c;
        c = exp_clr();
        if (rst) begin
            m_ch  <= '0;
            m_ovf <= 1'b0;
        end else begin
            m_ch  <= (m_ch & ~c[7:0]) | chan_evt;  // R6 set wins
            m_ovf <= (m_ovf & ~c[8]) | ovf_evt;
        end
    end

    task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // state check after an edge: flags, wrap flag, irq (R12)
    task automatic chk_state(input string req);
        chk(req, {ovf_flag, chan_flag}, {m_ovf, m_ch});
        chk("R12 irq", {8'b0, irq},
            {8'b0, (|(m_ch & chan_ie)) || (m_ovf && ovf_ie)});
    endtask

    // apply one bus cycle with events, check read data, clock, check state
    task automatic step(input string req, input logic s, input logic w,
                        input logic [4:0] a, input logic [7:0] d,
                        input logic [7:0] ev, input logic oe);
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        chan_evt = ev; ovf_evt = oe;
        #1;
        chk("R7 rdata", {1'b0, bus_rdata}, {1'b0, exp_rd()});
        @(posedge clk);
        @(negedge clk);
        bus_sel = 0; chan_evt = 0; ovf_evt = 0;
        chk_state(req);
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int seed = 17;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        chk("R1 reset", {ovf_flag, chan_flag}, 9'h000);
        chk("R1 irq", {8'b0, irq}, 9'h000);
        rst = 0;
        chan_ie = 8'hFF; ovf_ie = 1;
        tmr_en = 1;

        // R2 setting
        step("R2 set ch3", 0, 0, 0, 0, 8'h08, 0);
        chk("R2 ch3 literal", {ovf_flag, chan_flag}, 9'h008);
        step("R2 set all", 0, 0, 0, 0, 8'hFF, 1);
        // R3 write zero ignored, then write ones
        step("R3 zero write", 1, 1, 5'h0E, 8'h00, 0, 0);
        step("R3 clear 0x0F", 1, 1, 5'h0E, 8'h0F, 0, 0);
        chk("R3 literal", {ovf_flag, chan_flag}, 9'h1F0);
        // R4
        step("R4 bit7 clear", 1, 1, 5'h0F, 8'h7F, 0, 0);
        step("R4 clear wrap", 1, 1, 5'h0F, 8'h80, 0, 0);
        chk("R4 literal", {8'b0, ovf_flag}, 9'h000);
        // R5 both enables low
        step("R2 reload", 0, 0, 0, 0, 8'hFF, 1);
        tmr_en = 0; acc_en = 0;
        step("R5 ignored ch", 1, 1, 5'h0E, 8'hFF, 0, 0);
        step("R5 ignored wrap", 1, 1, 5'h0F, 8'h80, 0, 0);
        chk("R5 literal", {ovf_flag, chan_flag}, 9'h1FF);
        acc_en = 1;
        step("R5 acc enable clears", 1, 1, 5'h0E, 8'h03, 0, 0);
        chk("R5 acc literal", {ovf_flag, chan_flag}, 9'h1FC);
        // R6 set and clear together
        step("R6 collide", 1, 1, 5'h0E, 8'hFF, 8'h40, 0);
        chk("R6 literal", {ovf_flag, chan_flag}, 9'h140);
        // R7 reads
        step("R7 read flags", 1, 0, 5'h0E, 0, 0, 0);
        step("R7 read wrap", 1, 0, 5'h0F, 0, 0, 0);
        step("R7 read other", 1, 0, 5'h07, 0, 0, 0);
        // fast mode; oc_mode = F0: ch0..3 capture, ch4..7 compare
        step("R2 reload", 0, 0, 0, 0, 8'hFF, 1);
        fast_clr = 1; tmr_en = 0; acc_en = 0;
        step("R8 ch2 read high", 1, 0, 5'h14, 0, 0, 0);
        chk("R8 high literal", {1'b0, chan_flag}, 9'h0FB);
        step("R8 ch1 read low", 1, 0, 5'h13, 0, 0, 0);
        chk("R8 low literal", {1'b0, chan_flag}, 9'h0F9);
        step("R9 ch5 write high", 1, 1, 5'h1A, 8'h55, 0, 0);
        step("R9 ch6 write low", 1, 1, 5'h1D, 8'h55, 0, 0);
        chk("R9 literal", {1'b0, chan_flag}, 9'h099);
        step("R10 write capture", 1, 1, 5'h10, 8'h00, 0, 0);
        step("R10 read compare", 1, 0, 5'h1E, 0, 0, 0);
        chk("R10 literal", {1'b0, chan_flag}, 9'h099);
        step("R11 cnt high", 1, 0, 5'h04, 0, 0, 0);
        chk("R11 literal", {8'b0, ovf_flag}, 9'h000);
        step("R2 reload", 0, 0, 0, 0, 0, 1);
        step("R11 cnt low write", 1, 1, 5'h05, 8'h00, 0, 0);
        fast_clr = 0;
        step("R10 fast off", 1, 0, 5'h10, 0, 0, 0);
        chk("R10 off literal", {1'b0, chan_flag}, 9'h099);
        // R12 masking
        chan_ie = 8'h00; ovf_ie = 0;
        step("R12 masked", 0, 0, 0, 0, 0, 0);
        chan_ie = 8'h08;
        step("R12 single", 0, 0, 0, 0, 0, 0);

        // random phase
        oc_mode = 8'($urandom);
        for (int n = 0; n < 600; n++) begin
            logic [4:0] a;
            tmr_en = 1'($urandom); acc_en = 1'($urandom % 4 == 0);
            fast_clr = 1'($urandom); chan_ie = 8'($urandom);
            ovf_ie = 1'($urandom);
            case ($urandom % 5)
                0: a = 5'h0E;
                1: a = 5'h0F;
                2: a = 5'h04 + 5'($urandom % 2);
                default: a = 5'($urandom);
            endcase
            step("R3 R8 R9 R11 random", 1'($urandom % 4 != 0), 1'($urandom),
                 a, 8'($urandom), 8'($urandom & $urandom), 1'($urandom % 5 == 0));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule